// File: doc/BRIEF.md
# Vector Loop Replay Sequencer

This block sits between a scalar control core that can issue at most one instruction per cycle and a wide vector unit. The core first captures a short loop body of opaque vector instruction words into a small buffer. It then starts a replay with an iteration count and a starting register pointer. From that point the sequencer feeds the body to the vector unit on its own. The core and the vector unit exchange no data while the replay runs, so the core is free to run its own control code in parallel. This hides the loop overhead that a one-instruction-per-cycle core would otherwise pay on every pass.

No loop counter is passed into the body. Each instruction instead carries a register-index field, and the sequencer adds a running pointer to that field. The pointer starts at the programmed base and steps by one after every complete pass. A stall command from the core is held off until the replay has drained. This lets the core wait for the vector results before it hands them to the next consumer. A record or replay command that arrives during a replay is refused and flagged.

Top module: `vec_macro_unit`

## Requirements
- R1: After reset the unit is idle, with `vec_valid_o`, `busy_o`, `done_o`, `busy_err_o`, `recording_o` and `overflow_o` all low, `rec_len_o` at zero and `cmd_ready_o` high.
- R2: A command is accepted on a clock edge where `cmd_valid_i` and `cmd_ready_o` are both high. Command codes on `cmd_op_i`: 0 = start recording, 1 = append word, 2 = replay, 3 = stall. Start recording clears the body and raises `recording_o`. Each append stores `cmd_insn_i` at the next slot and increments `rec_len_o`. An append while `recording_o` is low has no effect. A replay command lowers `recording_o`.
- R3: Appends beyond DEPTH words are dropped. `rec_len_o` stays at DEPTH and `overflow_o` rises. `overflow_o` stays high until the next start-recording command, which clears it.
- R4: During a replay of N iterations, the body words are issued in recorded order, N times over. The sequencer issues one word per clock edge on which `vec_valid_o` and `vec_ready_i` are both high. `vec_valid_o` is high only while `busy_o` is high.
- R5: Each issued word equals the recorded word, except that bits [IDX_LSB+IDX_W-1:IDX_LSB] hold (recorded field + base + k) mod 2^IDX_W, where k is the zero-based iteration number. The base comes from `cmd_base_i` at the replay command.
- R6: A replay with an iteration count of zero, or with an empty body, issues nothing. `done_o` pulses for one cycle right after the accepting edge, and `busy_o` stays low.
- R7: After the handshake of the final word, `busy_o` is low and `done_o` is high for exactly one cycle.
- R8: A start-recording, append or replay command accepted while `busy_o` is high is rejected. `busy_err_o` pulses for one cycle after the accepting edge, and the body, `rec_len_o` and `recording_o` are unchanged.
- R9: A stall command is held off (`cmd_ready_o` low) while `busy_o` is high. It is accepted once the replay has drained.
- R10: While `vec_valid_o` is high and `vec_ready_i` is low, `vec_valid_o` and `vec_insn_o` hold their values into the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Core command valid |
| cmd_ready_o | output | 1 | Command accepted this cycle |
| cmd_op_i | input | 2 | Command code |
| cmd_insn_i | input | INSN_W | Instruction word for append |
| cmd_count_i | input | CNT_W | Iteration count for replay |
| cmd_base_i | input | IDX_W | Starting register pointer for replay |
| vec_valid_o | output | 1 | Instruction offered to the vector unit |
| vec_ready_i | input | 1 | Vector unit accepts the instruction |
| vec_insn_o | output | INSN_W | Instruction with patched index field |
| recording_o | output | 1 | Record mode active |
| rec_len_o | output | $clog2(DEPTH+1) | Number of body words held |
| overflow_o | output | 1 | Words dropped since last record start |
| busy_o | output | 1 | Replay in progress |
| done_o | output | 1 | One-cycle pulse at replay completion |
| busy_err_o | output | 1 | One-cycle pulse on a rejected command |

## Verification
The bench builds the unit with a four-word buffer, a 16-bit word and a 3-bit index field at bit 4. With a four-word buffer, overflow is reached after only a few appends. With a 3-bit field, the pointer wraps within a handful of iterations. Replays start at a base near the top of the field range, so the modulo addition is exercised in short runs. Backpressure patterns and a replay held off entirely by the vector unit bring the hold rule, command rejection and stall blocking into reach.

// File: rtl/vmu_pkg.sv
`timescale 1ns/1ps
package vmu_pkg;
  typedef enum logic [1:0] {
    OP_REC_START = 2'd0,
    OP_REC_WORD  = 2'd1,
    OP_REPLAY    = 2'd2,
    OP_STALL     = 2'd3
  } vmu_op_e;

  typedef enum logic {
    SEQ_IDLE = 1'b0,
    SEQ_RUN  = 1'b1
  } seq_state_e;
endpackage

// File: rtl/vmu_rec_buf.sv
`timescale 1ns/1ps
module vmu_rec_buf #(
  parameter int INSN_W = 32,
  parameter int DEPTH  = 16,
  localparam int AW    = $clog2(DEPTH),
  localparam int LW    = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              wr_i,
  input  logic [INSN_W-1:0] wr_data_i,
  input  logic [AW-1:0]     rd_addr_i,
  output logic [INSN_W-1:0] rd_data_o,
  output logic [LW-1:0]     len_o,
  output logic              ovf_o
);
  logic [INSN_W-1:0] mem_q [DEPTH];
  logic [LW-1:0]     len_q;
  logic              ovf_q;
  logic              has_room;

  assign has_room = (len_q < LW'(DEPTH));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      len_q <= '0;
      ovf_q <= 1'b0;
    end else if (clr_i) begin
      len_q <= '0;
      ovf_q <= 1'b0;
    end else if (wr_i) begin
      if (has_room) len_q <= len_q + 1'b1;
      else          ovf_q <= 1'b1;
    end
  end

  // storage needs no reset: len_q gates every read
  always_ff @(posedge clk_i) begin
    if (wr_i && !clr_i && has_room) mem_q[len_q[AW-1:0]] <= wr_data_i;
  end

  assign rd_data_o = mem_q[rd_addr_i];
  assign len_o     = len_q;
  assign ovf_o     = ovf_q;
endmodule

// File: rtl/vmu_idx_patch.sv
`timescale 1ns/1ps
module vmu_idx_patch #(
  parameter int INSN_W  = 32,
  parameter int IDX_LSB = 8,
  parameter int IDX_W   = 4
) (
  input  logic [INSN_W-1:0] insn_i,
  input  logic [IDX_W-1:0]  ptr_i,
  output logic [INSN_W-1:0] insn_o
);
  logic [IDX_W-1:0] field_sum;

  assign field_sum = insn_i[IDX_LSB +: IDX_W] + ptr_i;

  always_comb begin
    insn_o = insn_i;
    insn_o[IDX_LSB +: IDX_W] = field_sum;
  end
endmodule

// File: rtl/vmu_seq.sv
`timescale 1ns/1ps
module vmu_seq
  import vmu_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int IDX_W  = 4,
  parameter int CNT_W  = 16,
  parameter int STRIDE = 1,
  localparam int AW    = $clog2(DEPTH),
  localparam int LW    = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic [IDX_W-1:0] base_i,
  input  logic [LW-1:0]    len_i,
  input  logic             vec_ready_i,
  output logic             busy_o,
  output logic             vec_valid_o,
  output logic [AW-1:0]    pc_o,
  output logic [IDX_W-1:0] ptr_o,
  output logic             done_o
);
  seq_state_e       state_q;
  logic [AW-1:0]    pc_q;
  logic [CNT_W-1:0] iter_q;
  logic [IDX_W-1:0] ptr_q;
  logic             done_q;
  logic             fire;
  logic             last_word;
  logic             last_iter;

  assign fire      = (state_q == SEQ_RUN) && vec_ready_i;
  assign last_word = ((LW'(pc_q) + 1'b1) == len_i);
  assign last_iter = (iter_q == CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SEQ_IDLE;
      pc_q    <= '0;
      iter_q  <= '0;
      ptr_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (state_q == SEQ_IDLE) begin
        if (start_i) begin
          if (count_i == '0 || len_i == '0) begin
            done_q <= 1'b1;
          end else begin
            state_q <= SEQ_RUN;
            pc_q    <= '0;
            iter_q  <= count_i;
            ptr_q   <= base_i;
          end
        end
      end else if (fire) begin
        if (last_word) begin
          pc_q  <= '0;
          ptr_q <= ptr_q + IDX_W'(STRIDE);
          if (last_iter) begin
            state_q <= SEQ_IDLE;
            done_q  <= 1'b1;
          end else begin
            iter_q <= iter_q - 1'b1;
          end
        end else begin
          pc_q <= pc_q + 1'b1;
        end
      end
    end
  end

  assign busy_o      = (state_q == SEQ_RUN);
  assign vec_valid_o = (state_q == SEQ_RUN);
  assign pc_o        = pc_q;
  assign ptr_o       = ptr_q;
  assign done_o      = done_q;
endmodule

// File: rtl/vec_macro_unit.sv
`timescale 1ns/1ps
module vec_macro_unit
  import vmu_pkg::*;
#(
  parameter int INSN_W  = 32,
  parameter int DEPTH   = 16,
  parameter int IDX_LSB = 8,
  parameter int IDX_W   = 4,
  parameter int CNT_W   = 16,
  localparam int AW     = $clog2(DEPTH),
  localparam int LW     = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  output logic              cmd_ready_o,
  input  logic [1:0]        cmd_op_i,
  input  logic [INSN_W-1:0] cmd_insn_i,
  input  logic [CNT_W-1:0]  cmd_count_i,
  input  logic [IDX_W-1:0]  cmd_base_i,
  output logic              vec_valid_o,
  input  logic              vec_ready_i,
  output logic [INSN_W-1:0] vec_insn_o,
  output logic              recording_o,
  output logic [LW-1:0]     rec_len_o,
  output logic              overflow_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              busy_err_o
);
  vmu_op_e           op;
  logic              busy;
  logic              cmd_fire;
  logic              cmd_ok;
  logic              rec_start;
  logic              rec_word;
  logic              replay_go;
  logic              recording_q;
  logic              busy_err_q;
  logic [AW-1:0]     pc;
  logic [IDX_W-1:0]  ptr;
  logic [INSN_W-1:0] raw_insn;
  logic [LW-1:0]     len;

  assign op          = vmu_op_e'(cmd_op_i);
  assign cmd_ready_o = !((op == OP_STALL) && busy);
  assign cmd_fire    = cmd_valid_i && cmd_ready_o;
  assign cmd_ok      = cmd_fire && !busy;
  assign rec_start   = cmd_ok && (op == OP_REC_START);
  assign rec_word    = cmd_ok && (op == OP_REC_WORD) && recording_q;
  assign replay_go   = cmd_ok && (op == OP_REPLAY);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      recording_q <= 1'b0;
      busy_err_q  <= 1'b0;
    end else begin
      busy_err_q <= cmd_fire && busy && (op != OP_STALL);
      if (rec_start)      recording_q <= 1'b1;
      else if (replay_go) recording_q <= 1'b0;
    end
  end

  vmu_rec_buf #(
    .INSN_W (INSN_W),
    .DEPTH  (DEPTH)
  ) u_buf (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (rec_start),
    .wr_i      (rec_word),
    .wr_data_i (cmd_insn_i),
    .rd_addr_i (pc),
    .rd_data_o (raw_insn),
    .len_o     (len),
    .ovf_o     (overflow_o)
  );

  vmu_seq #(
    .DEPTH  (DEPTH),
    .IDX_W  (IDX_W),
    .CNT_W  (CNT_W),
    .STRIDE (1)
  ) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (replay_go),
    .count_i     (cmd_count_i),
    .base_i      (cmd_base_i),
    .len_i       (len),
    .vec_ready_i (vec_ready_i),
    .busy_o      (busy),
    .vec_valid_o (vec_valid_o),
    .pc_o        (pc),
    .ptr_o       (ptr),
    .done_o      (done_o)
  );

  vmu_idx_patch #(
    .INSN_W  (INSN_W),
    .IDX_LSB (IDX_LSB),
    .IDX_W   (IDX_W)
  ) u_patch (
    .insn_i (raw_insn),
    .ptr_i  (ptr),
    .insn_o (vec_insn_o)
  );

  assign recording_o = recording_q;
  assign rec_len_o   = len;
  assign busy_o      = busy;
  assign busy_err_o  = busy_err_q;
endmodule

// File: rtl/vmu_checker.sv
`timescale 1ns/1ps
module vmu_checker #(
  parameter int INSN_W = 32,
  parameter int DEPTH  = 16,
  parameter int IDX_W  = 4,
  parameter int CNT_W  = 16,
  localparam int LW    = $clog2(DEPTH + 1)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cmd_valid_i,
  input logic              cmd_ready_o,
  input logic [1:0]        cmd_op_i,
  input logic              vec_valid_o,
  input logic              vec_ready_i,
  input logic [INSN_W-1:0] vec_insn_o,
  input logic [LW-1:0]     rec_len_o,
  input logic              overflow_o,
  input logic              busy_o,
  input logic              done_o,
  input logic              busy_err_o
);
  assert_len_bound_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rec_len_o <= LW'(DEPTH));

  assert_ovf_full_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(overflow_o) |-> rec_len_o == LW'(DEPTH));

  assert_issue_busy_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_valid_o |-> busy_o);

  assert_done_idle_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  assert_reject_cause_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_err_o |-> $past(cmd_valid_i && busy_o && cmd_op_i != 2'd3));

  assert_body_frozen_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> $stable(rec_len_o));

  assert_stall_block_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && cmd_op_i == 2'd3 && busy_o) |-> !cmd_ready_o);

  assert_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vec_valid_o && !vec_ready_i) |=> (vec_valid_o && $stable(vec_insn_o)));
endmodule

bind vec_macro_unit vmu_checker #(
  .INSN_W (INSN_W),
  .DEPTH  (DEPTH),
  .IDX_W  (IDX_W),
  .CNT_W  (CNT_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cmd_valid_i (cmd_valid_i),
  .cmd_ready_o (cmd_ready_o),
  .cmd_op_i    (cmd_op_i),
  .vec_valid_o (vec_valid_o),
  .vec_ready_i (vec_ready_i),
  .vec_insn_o  (vec_insn_o),
  .rec_len_o   (rec_len_o),
  .overflow_o  (overflow_o),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .busy_err_o  (busy_err_o)
);

// File: tb/vec_macro_unit_tb.sv
`timescale 1ns/1ps
module vec_macro_unit_tb;
  localparam int INSN_W  = 16;
  localparam int DEPTH   = 4;
  localparam int IDX_LSB = 4;
  localparam int IDX_W   = 3;
  localparam int CNT_W   = 8;
  localparam int LW      = $clog2(DEPTH + 1);

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic              cmd_valid_i = 1'b0;
  logic              cmd_ready_o;
  logic [1:0]        cmd_op_i = '0;
  logic [INSN_W-1:0] cmd_insn_i = '0;
  logic [CNT_W-1:0]  cmd_count_i = '0;
  logic [IDX_W-1:0]  cmd_base_i = '0;
  logic              vec_valid_o;
  logic              vec_ready_i = 1'b1;
  logic [INSN_W-1:0] vec_insn_o;
  logic              recording_o;
  logic [LW-1:0]     rec_len_o;
  logic              overflow_o;
  logic              busy_o;
  logic              done_o;
  logic              busy_err_o;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  logic [INSN_W-1:0] shadow [DEPTH];
  int                shadow_len = 0;

  always #2.5 clk = ~clk;

  vec_macro_unit #(
    .INSN_W (INSN_W), .DEPTH (DEPTH), .IDX_LSB (IDX_LSB),
    .IDX_W (IDX_W), .CNT_W (CNT_W)
  ) u_dut (
    .clk_i (clk), .rst_ni (rst_ni),
    .cmd_valid_i (cmd_valid_i), .cmd_ready_o (cmd_ready_o),
    .cmd_op_i (cmd_op_i), .cmd_insn_i (cmd_insn_i),
    .cmd_count_i (cmd_count_i), .cmd_base_i (cmd_base_i),
    .vec_valid_o (vec_valid_o), .vec_ready_i (vec_ready_i),
    .vec_insn_o (vec_insn_o), .recording_o (recording_o),
    .rec_len_o (rec_len_o), .overflow_o (overflow_o),
    .busy_o (busy_o), .done_o (done_o), .busy_err_o (busy_err_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [INSN_W-1:0] patch(input logic [INSN_W-1:0] w, input int p);
    logic [INSN_W-1:0] r;
    r = w;
    r[IDX_LSB +: IDX_W] = w[IDX_LSB +: IDX_W] + IDX_W'(p);
    return r;
  endfunction

  // drive at negedge, wait for acceptance, return at the negedge after the accepting edge
  task automatic send_cmd(input logic [1:0] op, input logic [INSN_W-1:0] insn,
                          input int cnt, input int base);
    @(negedge clk);
    cmd_valid_i = 1'b1; cmd_op_i = op; cmd_insn_i = insn;
    cmd_count_i = CNT_W'(cnt); cmd_base_i = IDX_W'(base);
    #1;
    while (!cmd_ready_o) begin @(negedge clk); #1; end
    @(negedge clk);
    cmd_valid_i = 1'b0;
  endtask

  task automatic record_words(input logic [INSN_W-1:0] w [8], input int n);
    send_cmd(2'd0, '0, 0, 0);
    shadow_len = 0;
    for (int i = 0; i < n; i++) begin
      send_cmd(2'd1, w[i], 0, 0);
      if (shadow_len < DEPTH) begin shadow[shadow_len] = w[i]; shadow_len++; end
    end
  endtask

  task automatic run_replay(input string req, input int cnt, input int base, input bit bp);
    int k = 0;
    int cyc = 0;
    bit held = 0;
    logic [INSN_W-1:0] held_val = '0;
    int total;
    total = (shadow_len == 0) ? 0 : cnt * shadow_len;
    send_cmd(2'd2, '0, cnt, base);
    forever begin
      vec_ready_i = bp ? ((cyc % 3) != 1) : 1'b1;
      #1;
      if (done_o) break;
      if (vec_valid_o) begin
        if (held) chk("R10 hold", {16'h0, vec_insn_o}, {16'h0, held_val});
        if (vec_ready_i) begin
          if (k < total)
            chk({req, " R5 word"}, {16'h0, vec_insn_o},
                {16'h0, patch(shadow[k % shadow_len], base + k / shadow_len)});
          k++;
          held = 0;
        end else begin
          held = 1; held_val = vec_insn_o;
        end
      end
      cyc++;
      if (cyc > 400) begin chk({req, " R7 no done"}, 0, 1); break; end
      @(negedge clk);
    end
    chk({req, " R4 issue count"}, k, total);
    chk({req, " R7 busy low at done"}, busy_o, 0);
    @(negedge clk); #1;
    chk({req, " R7 done one cycle"}, done_o, 0);
    vec_ready_i = 1'b1;
  endtask

  task automatic t_reset();
    #1;
    chk("R1 ready", cmd_ready_o, 1);
    chk("R1 valid", vec_valid_o, 0);
    chk("R1 busy", busy_o, 0);
    chk("R1 len", rec_len_o, 0);
    chk("R1 ovf", overflow_o, 0);
    chk("R1 done", done_o, 0);
    chk("R1 err", busy_err_o, 0);
    chk("R1 rec", recording_o, 0);
  endtask

  task automatic t_basic();
    logic [INSN_W-1:0] w [8] = '{16'hA105, 16'h3B20, 16'hC471, 0, 0, 0, 0, 0};
    record_words(w, 3);
    chk("R2 len", rec_len_o, 3);
    chk("R2 recording", recording_o, 1);
    run_replay("basic", 2, 0, 0);
    chk("R2 recording cleared", recording_o, 0);
    send_cmd(2'd1, 16'hFFFF, 0, 0);
    chk("R2 append ignored", rec_len_o, 3);
    run_replay("after ignored append", 1, 0, 0);
  endtask

  task automatic t_backpressure();
    run_replay("backpressure wrap", 4, 6, 1);
  endtask

  task automatic t_zero();
    int seen = 0;
    send_cmd(2'd2, '0, 0, 3);
    #1;
    chk("R6 zero done", done_o, 1);
    chk("R6 zero busy", busy_o, 0);
    if (vec_valid_o) seen++;
    chk("R6 zero no issue", seen, 0);
  endtask

  task automatic t_overflow();
    logic [INSN_W-1:0] w [8] = '{16'h1010, 16'h2070, 16'h3050, 16'h4060,
                                 16'h5555, 16'h6666, 0, 0};
    record_words(w, 6);
    #1;
    chk("R3 len sat", rec_len_o, DEPTH);
    chk("R3 ovf set", overflow_o, 1);
    run_replay("overflow body", 1, 2, 0);
    send_cmd(2'd0, '0, 0, 0);
    shadow_len = 0;
    #1;
    chk("R3 ovf cleared", overflow_o, 0);
    chk("R3 len cleared", rec_len_o, 0);
    send_cmd(2'd2, '0, 5, 0);
    #1;
    chk("R6 empty done", done_o, 1);
    chk("R6 empty busy", busy_o, 0);
  endtask

  task automatic t_busy();
    logic [INSN_W-1:0] w [8] = '{16'h0E30, 16'h0D40, 0, 0, 0, 0, 0, 0};
    int waits = 0;
    record_words(w, 2);
    vec_ready_i = 1'b0;
    send_cmd(2'd2, '0, 1, 1);
    #1;
    chk("R8 busy up", busy_o, 1);
    send_cmd(2'd1, 16'h7777, 0, 0);
    #1;
    chk("R8 append err", busy_err_o, 1);
    chk("R8 len kept", rec_len_o, 2);
    send_cmd(2'd0, '0, 0, 0);
    #1;
    chk("R8 start err", busy_err_o, 1);
    chk("R8 len kept2", rec_len_o, 2);
    chk("R8 rec kept", recording_o, 0);
    @(negedge clk);
    cmd_valid_i = 1'b1; cmd_op_i = 2'd3;
    #1;
    chk("R9 stall held", cmd_ready_o, 0);
    @(negedge clk);
    vec_ready_i = 1'b1;
    #1;
    while (!cmd_ready_o && waits < 20) begin @(negedge clk); #1; waits++; end
    chk("R9 accepted when idle", busy_o, 0);
    chk("R9 drained in time", (waits <= 3) ? 1 : 0, 1);
    @(negedge clk);
    cmd_valid_i = 1'b0;
    #1;
    chk("R8 no err on stall", busy_err_o, 0);
    run_replay("after busy", 2, 5, 0);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    @(negedge clk);
    rst_ni = 1'b1;
    t_basic();
    t_backpressure();
    t_zero();
    t_overflow();
    t_busy();
    repeat (2) @(negedge clk);
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule